// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block is the counting core of a real-time clock. It keeps seconds, minutes, hours, weekday, day of month, month and two-digit year as packed BCD bytes, with one decimal digit in each nibble. The core advances them once per second. The host drives a 32,768 Hz clock enable into the block. A prescaler divides that enable down to a one-second tick. Carries then run through the fields by calendar rules, and the same clock cycle updates every field that changes.

A host loads or reads each field through a small addressed register port. Reads are combinational, and a write takes effect on the next clock edge. Bit 7 of the seconds byte is a halt flag. At reset the flag is set, so the clock stays stopped until software writes the seconds byte with that bit clear. A field accepts any value, including one that is not valid BCD. Such a value keeps counting up until it equals the field's rollover value, and then it returns to the field's minimum.

Field addresses: 0 seconds (bit 7 = halt), 1 minutes, 2 hours (24-hour), 3 weekday, 4 day of month, 5 month, 6 year, 7 general control byte.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, addresses 0 to 7 read 0x80, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00 and 0x00. The clock is therefore halted at 00:00:00, weekday 1, 01/01/00.
- R2: Bits that a field does not use are dropped on a write and read back as zero. Writing 0xFF gives 0x7F at minutes, 0x3F at hours, 0x07 at weekday, 0x3F at day of month and 0x1F at month.
- R3: While bit 7 of the seconds byte is 1, no enable pulse changes any time or date field.
- R4: A write to address 0 clears the prescaler. From there, exactly 2^PRESC_W enable pulses advance the seconds by one, and 2^PRESC_W-1 pulses leave it unchanged.
- R5: Seconds carry into minutes at 59, minutes carry into hours at 59, and hours wrap from 23 to 00. At 23:59:59 a single tick yields 00:00:00 and advances the date in that same cycle.
- R6: The weekday advances at each midnight wrap and goes from 7 back to 1. It neither drives nor depends on any other field.
- R7: The day of month wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in every other month except 02. The month then advances.
- R8: February ends after 29 when the BCD year is a multiple of four (for example 00 or 24), and after 28 otherwise.
- R9: At the end of 12/31, the month wraps to 01 and the year advances. Year 99 wraps to 00.
- R10: A field whose low digit is 9 steps to the next tens digit with a zero low digit. Any other value steps up by one in binary. The field leaves its maximum only on an exact match, so a seconds value of 0x6A counts 0x6B ... 0x6F, 0x70 and carries nothing into the minutes.
- R11: Address 7 stores and returns all 8 bits, and its value has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick32k_i | input | 1 | 32,768 Hz enable, high for one clock cycle per oscillator period |
| we_i | input | 1 | Write strobe for the addressed byte |
| addr_i | input | 3 | Register address (0 to 7) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |

## Verification
A write is captured on the rising edge that samples we_i, and its value is readable from the next falling edge. The bench therefore reads back one half cycle after each write edge. A tick updates every affected field on the rising edge that carries the 2^PRESC_W-th enable since the last seconds write. Each scenario sends exactly that many enable pulses, or one fewer, and reads every field at the falling edge that follows, so that the whole carry ripple is seen as one atomic step. The bench sets PRESC_W to 4, which makes one second equal to 16 enables.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NUM_FIELDS = 7;
  localparam logic [2:0] ADDR_SEC  = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd7;

  // Bits each field keeps. Bit 7 of the seconds byte is held outside the field.
  function automatic logic [7:0] field_mask(int unsigned idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 4:    return 8'h3F;
      3:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] field_min(int unsigned idx);
    case (idx)
      3, 4, 5: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  // Digit-wise step: a low digit of 9 becomes 0 and the tens digit moves up; otherwise binary +1
  function automatic logic [7:0] bcd_step(logic [7:0] v, logic [7:0] mask);
    logic [7:0] nxt;
    if (v[3:0] == 4'h9) nxt = {v[7:4] + 4'h1, 4'h0};
    else                nxt = v + 8'h01;
    return nxt & mask;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             halt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (en_i && !halt_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && !halt_i && !clr_i && (cnt_q == CntMax);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] MASK = 8'hFF,
  parameter logic [7:0] MIN  = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic [7:0] max_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);
  import rtc_pkg::*;

  logic [7:0] val_q;
  logic       at_max;

  assign at_max = (val_q == max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= MIN;
    else if (we_i)  val_q <= wdata_i & MASK;
    else if (inc_i) val_q <= at_max ? MIN : bcd_step(val_q, MASK);
  end

  assign wrap_o = inc_i && at_max;
  assign val_o  = val_q;
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] month_i,
  input  logic       yr_tens_lsb_i,
  input  logic [1:0] yr_unit_i,
  output logic [7:0] last_day_o
);
  logic [1:0] mod4;
  logic       leap;

  // (10*tens + units) mod 4 == (2*tens + units) mod 4
  assign mod4 = yr_unit_i + {yr_tens_lsb_i, 1'b0};
  assign leap = (mod4 == 2'd0);

  always_comb begin
    case (month_i)
      8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core #(
  parameter int unsigned PRESC_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick32k_i,
  input  logic       we_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  import rtc_pkg::*;

  logic [NUM_FIELDS-1:0][7:0] fld_q;
  logic [NUM_FIELDS-1:0][7:0] fld_max;
  logic [NUM_FIELDS-1:0]      fld_inc;
  logic [NUM_FIELDS-1:0]      fld_wrap;
  logic [NUM_FIELDS-1:0]      fld_we;
  logic [PRESC_W-1:0]         presc_cnt;
  logic                       sec_tick;
  logic                       halt_q;
  logic [7:0]                 ctrl_q;
  logic [7:0]                 last_day;
  logic                       sec_wr;

  assign sec_wr = we_i && (addr_i == ADDR_SEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b1;
      ctrl_q <= 8'h00;
    end else if (we_i) begin
      if (addr_i == ADDR_SEC)  halt_q <= wdata_i[7];
      if (addr_i == ADDR_CTRL) ctrl_q <= wdata_i;
    end
  end

  rtc_prescaler #(.CNT_W(PRESC_W)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick32k_i),
    .halt_i (halt_q),
    .clr_i  (sec_wr),
    .cnt_o  (presc_cnt),
    .tick_o (sec_tick)
  );

  rtc_month_len i_mlen (
    .month_i       (fld_q[5]),
    .yr_tens_lsb_i (fld_q[6][4]),
    .yr_unit_i     (fld_q[6][1:0]),
    .last_day_o    (last_day)
  );

  // Carry chain: sec -> min -> hour -> {weekday, date} ; date -> month -> year
  assign fld_inc[0] = sec_tick;
  assign fld_inc[1] = fld_wrap[0];
  assign fld_inc[2] = fld_wrap[1];
  assign fld_inc[3] = fld_wrap[2];
  assign fld_inc[4] = fld_wrap[2];
  assign fld_inc[5] = fld_wrap[4];
  assign fld_inc[6] = fld_wrap[5];

  assign fld_max[0] = 8'h59;
  assign fld_max[1] = 8'h59;
  assign fld_max[2] = 8'h23;
  assign fld_max[3] = 8'h07;
  assign fld_max[4] = last_day;
  assign fld_max[5] = 8'h12;
  assign fld_max[6] = 8'h99;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    assign fld_we[gi] = we_i && (addr_i == 3'(gi));

    rtc_bcd_field #(
      .MASK (field_mask(gi)),
      .MIN  (field_min(gi))
    ) i_field (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (fld_inc[gi]),
      .max_i   (fld_max[gi]),
      .we_i    (fld_we[gi]),
      .wdata_i (wdata_i),
      .val_o   (fld_q[gi]),
      .wrap_o  (fld_wrap[gi])
    );
  end

  always_comb begin
    if (addr_i == ADDR_SEC)       rdata_o = {halt_q, fld_q[0][6:0]};
    else if (addr_i == ADDR_CTRL) rdata_o = ctrl_q;
    else                          rdata_o = fld_q[addr_i];
  end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk #(
  parameter int unsigned PRESC_W = 15
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick32k_i,
  input logic                 we_i,
  input logic [2:0]           addr_i,
  input logic [7:0]           rdata_o,
  input logic [6:0][7:0]      fld_q,
  input logic                 halt_q,
  input logic                 sec_tick,
  input logic [PRESC_W-1:0]   presc_cnt
);
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !we_i) |=> $stable(fld_q)); // R3

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick |-> (tick32k_i && !halt_q)); // R4

  AST_PRESC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd0) |=> (presc_cnt == '0)); // R4

  AST_MIN_NEEDS_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && fld_q[0] != 8'h59) |=> $stable(fld_q[1])); // R5

  AST_WEEKDAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && fld_q[3] == 8'h07) |=> (fld_q[3] == 8'h07 || fld_q[3] == 8'h01)); // R6

  AST_YEAR_NEEDS_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && fld_q[5] != 8'h12) |=> $stable(fld_q[6])); // R9

  AST_MONTH_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd5) |-> (rdata_o[7:5] == 3'b000)); // R2
endmodule

bind rtc_bcd_core rtc_bcd_core_chk #(.PRESC_W(PRESC_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick32k_i (tick32k_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .fld_q     (fld_q),
  .halt_q    (halt_q),
  .sec_tick  (sec_tick),
  .presc_cnt (presc_cnt)
);

// File: tb/test_rtc_bcd_core.sv
`timescale 1ns/1ps
module test_rtc_bcd_core;
  localparam int unsigned PW  = 4;
  localparam int unsigned SEC = 1 << PW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick32k = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_bcd_core #(.PRESC_W(PW)) i_rtc_bcd_core (
    .clk_i(clk), .rst_ni(rst_n), .tick32k_i(tick32k),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: got %02h expected %02h", req, a, rdata, exp);
    end
  endtask

  task automatic pulses(input int n);
    @(negedge clk); tick32k = 1'b1;
    repeat (n) @(negedge clk);
    tick32k = 1'b0;
  endtask

  // Loads all fields, seconds last so the prescaler starts from zero
  task automatic set_time(input logic [7:0] yr, mo, dt, dy, hr, mi, se);
    wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, dy);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
  endtask

  task automatic t_reset;
    chk(3'd0, 8'h80, "R1"); chk(3'd1, 8'h00, "R1"); chk(3'd2, 8'h00, "R1");
    chk(3'd3, 8'h01, "R1"); chk(3'd4, 8'h01, "R1"); chk(3'd5, 8'h01, "R1");
    chk(3'd6, 8'h00, "R1"); chk(3'd7, 8'h00, "R1");
  endtask

  task automatic t_halt;
    pulses(3 * SEC);
    chk(3'd0, 8'h80, "R3"); chk(3'd1, 8'h00, "R3");
    wr(3'd0, 8'h85);
    pulses(2 * SEC);
    chk(3'd0, 8'h85, "R3");
  endtask

  task automatic t_prescale;
    wr(3'd0, 8'h00);
    pulses(SEC - 1);
    chk(3'd0, 8'h00, "R4");
    pulses(1);
    chk(3'd0, 8'h01, "R4");
    pulses(SEC - 3);
    wr(3'd0, 8'h10); // clears prescaler mid-second
    pulses(SEC - 1);
    chk(3'd0, 8'h10, "R4");
    pulses(1);
    chk(3'd0, 8'h11, "R4");
  endtask

  task automatic t_mask;
    wr(3'd0, 8'h80);
    wr(3'd1, 8'hFF); chk(3'd1, 8'h7F, "R2");
    wr(3'd2, 8'hFF); chk(3'd2, 8'h3F, "R2");
    wr(3'd3, 8'hFF); chk(3'd3, 8'h07, "R2");
    wr(3'd4, 8'hFF); chk(3'd4, 8'h3F, "R2");
    wr(3'd5, 8'hFF); chk(3'd5, 8'h1F, "R2");
    wr(3'd7, 8'hA5); chk(3'd7, 8'hA5, "R11");
  endtask

  task automatic t_midnight;
    set_time(8'h21, 8'h03, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk(3'd0, 8'h00, "R5"); chk(3'd1, 8'h00, "R5"); chk(3'd2, 8'h00, "R5");
    chk(3'd3, 8'h01, "R6"); chk(3'd4, 8'h16, "R5"); chk(3'd5, 8'h03, "R5");
    chk(3'd6, 8'h21, "R5"); chk(3'd7, 8'hA5, "R11");
    set_time(8'h21, 8'h03, 8'h16, 8'h03, 8'h12, 8'h30, 8'h59);
    pulses(SEC);
    chk(3'd1, 8'h31, "R5"); chk(3'd3, 8'h03, "R6"); chk(3'd4, 8'h16, "R6");
  endtask

  task automatic t_months;
    set_time(8'h22, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk(3'd4, 8'h01, "R7"); chk(3'd5, 8'h05, "R7");
    set_time(8'h22, 8'h05, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk(3'd4, 8'h31, "R7"); chk(3'd5, 8'h05, "R7");
    set_time(8'h22, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk(3'd4, 8'h01, "R7"); chk(3'd5, 8'h02, "R7");
    set_time(8'h22, 8'h11, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk(3'd4, 8'h01, "R7"); chk(3'd5, 8'h12, "R7");
  endtask

  task automatic t_leap;
    set_time(8'h24, 8'h02, 8'h28, 8'h04, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk(3'd4, 8'h29, "R8"); chk(3'd5, 8'h02, "R8");
    set_time(8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk(3'd4, 8'h01, "R8"); chk(3'd5, 8'h03, "R8");
    set_time(8'h23, 8'h02, 8'h28, 8'h04, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk(3'd4, 8'h01, "R8"); chk(3'd5, 8'h03, "R8");
    set_time(8'h00, 8'h02, 8'h28, 8'h04, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk(3'd4, 8'h29, "R8");
    set_time(8'h10, 8'h02, 8'h28, 8'h04, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk(3'd4, 8'h01, "R8");
  endtask

  task automatic t_year;
    set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk(3'd0, 8'h00, "R9"); chk(3'd2, 8'h00, "R9"); chk(3'd4, 8'h01, "R9");
    chk(3'd5, 8'h01, "R9"); chk(3'd6, 8'h00, "R9"); chk(3'd3, 8'h06, "R9");
  endtask

  task automatic t_invalid;
    set_time(8'h30, 8'h06, 8'h10, 8'h01, 8'h08, 8'h00, 8'h6A);
    pulses(SEC);
    chk(3'd0, 8'h6B, "R10"); chk(3'd1, 8'h00, "R10");
    pulses(5 * SEC);
    chk(3'd0, 8'h70, "R10"); chk(3'd1, 8'h00, "R10");
    wr(3'd0, 8'h49);
    pulses(SEC);
    chk(3'd0, 8'h50, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_halt();
    t_prescale();
    t_mask();
    t_midnight();
    t_months();
    t_leap();
    t_year();
    t_invalid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule